// File: doc/BRIEF.md
# Paged indirect register access sequencer

This block sits on the host side of a management bus and turns a single paged register access into the series of 16-bit management transactions that an indirect register bridge expects. The bridge sits at one fixed PHY address. A request names an 8-bit page, an 8-bit offset inside that page, a width of 8, 16, 32, 48 or 64 bits, and a direction. A write request also carries up to 64 bits of data. The block selects the page, stages any write data, issues a command word, and polls the command register until the bridge reports the operation finished. For a read it then collects the data words. The access ends with a one-cycle done or error pulse, and for a read the assembled value is presented with that pulse.

The block remembers the last page it selected successfully, so a run of accesses to the same page pays for the page write only once. Polling is bounded. A configurable number of idle cycles separates polls. Any transaction that the management port reports as failed ends the access at once. Only one access is in flight: the request side accepts a new request only while the block is idle.

Top module: `paged_access_seq`

## Requirements
- R1: After reset, req_ready is 1, rsp_done, rsp_error and mgmt_valid are 0, and the page cache holds 0xFF, so the first access always begins with a page-select write.
- R2: A page-select write is a write to register 0x10 with data {page, 7'b0, 1'b1}. It is issued only when the requested page differs from the cached page. The cache takes the new page when that write completes without error.
- R3: For a write access, before the command, the block writes data word i (bits 16i+15:16i of req_wdata) to register 0x18+i, for i from 0 upward. It writes 1, 1, 2, 3 or 4 words for width codes 0, 1, 2, 3 and 4 (8, 16, 32, 48, 64 bits). Width codes 5 to 7 behave as code 4.
- R4: The command is a write to register 0x11 with data {offset, 6'b0, read, write}: bit 1 is set for a read and bit 0 for a write.
- R5: After the command, the block reads register 0x11 until bits 1:0 read back as 00, with at most POLL_LIMIT (default 5) reads. If the last allowed read still shows a set bit, the access ends with rsp_error. Between two polls, mgmt_valid stays low for exactly POLL_GAP (default 4) cycles.
- R6: For a read access, after a successful poll, the block reads registers 0x18+i with the same word count as R3. Word i goes to rsp_rdata bits 16i+15:16i and unfilled bits are 0. A width-8 result keeps only its low byte. A write access returns rsp_done with rsp_rdata 0.
- R7: A management transaction that ends with mgmt_error ends the access with rsp_error on the next cycle, with no further transaction. A failed page-select write leaves the cache unchanged, so the next access to that page selects it again.
- R8: From the cycle after a request is accepted until rsp_done or rsp_error, req_ready is 0. rsp_done and rsp_error are single-cycle pulses and never high together.
- R9: Every transaction uses PHY address PHY_ADDR. While mgmt_valid is high and neither mgmt_done nor mgmt_error has arrived, the register, data and direction stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Block idle, request accepted when valid |
| req_write | input | 1 | 1 for write access, 0 for read |
| req_page | input | 8 | Register page |
| req_offset | input | 8 | Register offset within page |
| req_width | input | 3 | Width code: 0=8, 1=16, 2=32, 3=48, 4..7=64 bits |
| req_wdata | input | 64 | Write data, low word first |
| rsp_done | output | 1 | Access finished without error (pulse) |
| rsp_error | output | 1 | Access aborted (pulse) |
| rsp_rdata | output | 64 | Read result, valid with rsp_done |
| mgmt_valid | output | 1 | Management transaction requested |
| mgmt_write | output | 1 | 1 write, 0 read |
| mgmt_phy | output | 5 | Target PHY address |
| mgmt_reg | output | 5 | Target register number |
| mgmt_wdata | output | 16 | Write data of transaction |
| mgmt_done | input | 1 | Transaction completed (pulse) |
| mgmt_error | input | 1 | Transaction failed (pulse) |
| mgmt_rdata | input | 16 | Read data, valid with mgmt_done |

## Verification
A stale or corrupted page cache shows up at the management port in the very next access, as a missing or extra write to register 0x10. The bench compares the whole transaction list of every access with an expected list, so this is caught at once. A wrong word counter or index shows up as a wrong register number, a wrong staged data word or misplaced bits in rsp_rdata when the access completes. A wrong poll counter shows up as too many or too few reads of 0x11 before the error. A broken gap counter shows up as a wrong run of idle cycles between polls. Error handling that fails to abort shows up as a further transaction after the failed one, or as a late or missing rsp_error pulse.

// File: rtl/paged_access_seq.sv
module paged_access_seq #(
  parameter logic [4:0] PHY_ADDR = 5'd30,
  parameter int POLL_LIMIT = 5,
  parameter int POLL_GAP = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [7:0]  req_page,
  input  logic [7:0]  req_offset,
  input  logic [2:0]  req_width,
  input  logic [63:0] req_wdata,
  output logic        rsp_done,
  output logic        rsp_error,
  output logic [63:0] rsp_rdata,
  output logic        mgmt_valid,
  output logic        mgmt_write,
  output logic [4:0]  mgmt_phy,
  output logic [4:0]  mgmt_reg,
  output logic [15:0] mgmt_wdata,
  input  logic        mgmt_done,
  input  logic        mgmt_error,
  input  logic [15:0] mgmt_rdata
);

  localparam int PCW = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;
  localparam int GCW = (POLL_GAP > 1) ? $clog2(POLL_GAP) : 1;
  localparam logic [4:0] REG_PAGE = 5'h10;
  localparam logic [4:0] REG_CMD  = 5'h11;
  localparam logic [4:0] REG_DATA = 5'h18;
  localparam logic [7:0] PAGE_NONE = 8'hFF;

  typedef enum logic [2:0] {S_IDLE, S_PAGE, S_WDAT, S_CMD, S_POLL, S_GAP, S_RDAT} state_t;

  state_t      state;
  logic [7:0]  page_q;
  logic        r_write, r_b8;
  logic [7:0]  r_page, r_off;
  logic [1:0]  r_last, idx;
  logic [63:0] wdata_q, rdata_q;
  logic [PCW-1:0] pcnt;
  logic [GCW-1:0] gcnt;
  logic        done_q, err_q;

  function automatic logic [1:0] last_word(input logic [2:0] w);
    case (w)
      3'd0, 3'd1: return 2'd0;
      3'd2:       return 2'd1;
      3'd3:       return 2'd2;
      default:    return 2'd3;
    endcase
  endfunction

  assign req_ready  = (state == S_IDLE);
  assign rsp_done   = done_q;
  assign rsp_error  = err_q;
  assign rsp_rdata  = rdata_q;
  assign mgmt_phy   = PHY_ADDR;
  assign mgmt_valid = (state != S_IDLE) && (state != S_GAP);
  assign mgmt_write = (state == S_PAGE) || (state == S_WDAT) || (state == S_CMD);

  always_comb begin
    mgmt_reg   = REG_CMD;
    mgmt_wdata = 16'h0000;
    case (state)
      S_PAGE: begin
        mgmt_reg   = REG_PAGE;
        mgmt_wdata = {r_page, 7'b0, 1'b1};
      end
      S_WDAT: begin
        mgmt_reg   = REG_DATA + {3'b0, idx};
        mgmt_wdata = wdata_q[idx*16 +: 16];
      end
      S_CMD:  mgmt_wdata = {r_off, 6'b0, ~r_write, r_write};
      S_RDAT: mgmt_reg = REG_DATA + {3'b0, idx};
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      page_q  <= PAGE_NONE;
      r_write <= 1'b0;
      r_b8    <= 1'b0;
      r_page  <= 8'h00;
      r_off   <= 8'h00;
      r_last  <= 2'd0;
      idx     <= 2'd0;
      wdata_q <= 64'h0;
      rdata_q <= 64'h0;
      pcnt    <= '0;
      gcnt    <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          r_write <= req_write;
          r_page  <= req_page;
          r_off   <= req_offset;
          r_last  <= last_word(req_width);
          r_b8    <= (req_width == 3'd0);
          wdata_q <= req_wdata;
          rdata_q <= 64'h0;
          idx     <= 2'd0;
          if (req_page != page_q) state <= S_PAGE;
          else if (req_write)     state <= S_WDAT;
          else                    state <= S_CMD;
        end
        S_GAP: begin
          if (gcnt == GCW'(POLL_GAP - 1)) state <= S_POLL;
          else gcnt <= gcnt + 1'b1;
        end
        default: begin
          if (mgmt_error) begin
            err_q <= 1'b1;
            state <= S_IDLE;
          end else if (mgmt_done) begin
            case (state)
              S_PAGE: begin
                page_q <= r_page;
                state  <= r_write ? S_WDAT : S_CMD;
              end
              S_WDAT: begin
                if (idx == r_last) state <= S_CMD;
                else idx <= idx + 1'b1;
              end
              S_CMD: begin
                pcnt  <= '0;
                state <= S_POLL;
              end
              S_POLL: begin
                if (mgmt_rdata[1:0] == 2'b00) begin
                  if (r_write) begin
                    done_q <= 1'b1;
                    state  <= S_IDLE;
                  end else begin
                    idx   <= 2'd0;
                    state <= S_RDAT;
                  end
                end else if (pcnt == PCW'(POLL_LIMIT - 1)) begin
                  err_q <= 1'b1;
                  state <= S_IDLE;
                end else begin
                  pcnt  <= pcnt + 1'b1;
                  gcnt  <= '0;
                  state <= (POLL_GAP > 0) ? S_GAP : S_POLL;
                end
              end
              S_RDAT: begin
                rdata_q[idx*16 +: 16] <= r_b8 ? {8'h00, mgmt_rdata[7:0]} : mgmt_rdata;
                if (idx == r_last) begin
                  done_q <= 1'b1;
                  state  <= S_IDLE;
                end else idx <= idx + 1'b1;
              end
              default: ;
            endcase
          end
        end
      endcase
    end
  end

  p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  p_rsp_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_done && rsp_error));

  p_abort_on_error_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mgmt_valid && mgmt_error |=> rsp_error && !mgmt_valid);

  p_txn_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mgmt_valid && !mgmt_done && !mgmt_error |=>
      mgmt_valid && $stable(mgmt_reg) && $stable(mgmt_wdata) && $stable(mgmt_write));

  p_poll_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_POLL && mgmt_done && !mgmt_error && mgmt_rdata[1:0] != 2'b00 &&
      pcnt == PCW'(POLL_LIMIT - 1) |=> rsp_error);

  p_byte_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done && !r_write && r_b8 |-> rsp_rdata[63:8] == 56'h0);

endmodule

// File: tb/paged_access_seq_tb.sv
module paged_access_seq_tb;
  localparam int LIMIT = 5;
  localparam int GAP = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [7:0]  req_page = 8'h00, req_offset = 8'h00;
  logic [2:0]  req_width = 3'd0;
  logic [63:0] req_wdata = 64'h0;
  logic        rsp_done, rsp_error;
  logic [63:0] rsp_rdata;
  logic        mvalid, mwrite, mdone, merr;
  logic [4:0]  mphy, mreg;
  logic [15:0] mwdata, mrdata;

  paged_access_seq #(.PHY_ADDR(5'd30), .POLL_LIMIT(LIMIT), .POLL_GAP(GAP)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_page(req_page), .req_offset(req_offset),
    .req_width(req_width), .req_wdata(req_wdata), .rsp_done(rsp_done),
    .rsp_error(rsp_error), .rsp_rdata(rsp_rdata), .mgmt_valid(mvalid),
    .mgmt_write(mwrite), .mgmt_phy(mphy), .mgmt_reg(mreg), .mgmt_wdata(mwdata),
    .mgmt_done(mdone), .mgmt_error(merr), .mgmt_rdata(mrdata));

  int checks = 0, failures = 0;

  // bridge model
  logic [7:0]  m_page;
  logic [15:0] m_dreg [4];
  logic [15:0] m_cmd;
  logic [63:0] mem [32];
  int busy_left, cfg_busy = 0, cfg_err = -1;
  int log_n = 0;
  logic [4:0]  log_reg [64];
  logic        log_wr [64];
  logic [15:0] log_wd [64];
  int idle_run = 0, gap_seen = 0, gap_bad = 0, phy_bad = 0, wait_cnt = 0;
  logic in_txn = 1'b0, last_poll = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mdone <= 1'b0; merr <= 1'b0; mrdata <= 16'h0;
      in_txn = 1'b0; last_poll = 1'b0; idle_run = 0; busy_left = 0;
      m_page = 8'h00; m_cmd = 16'h0;
    end else begin
      if (!mvalid) idle_run = idle_run + 1;
      if (mdone || merr) begin
        mdone <= 1'b0; merr <= 1'b0;
      end else if (mvalid) begin
        if (!in_txn) begin
          in_txn = 1'b1;
          wait_cnt = int'($urandom % 3);
          if (mreg == 5'h11 && !mwrite && last_poll) begin
            gap_seen = gap_seen + 1;
            if (idle_run != GAP) gap_bad = gap_bad + 1;
          end
          idle_run = 0;
          if (mphy != 5'd30) phy_bad = phy_bad + 1;
        end
        if (wait_cnt > 0) wait_cnt = wait_cnt - 1;
        else begin
          in_txn = 1'b0;
          if (log_n < 64) begin
            log_reg[log_n] = mreg; log_wr[log_n] = mwrite; log_wd[log_n] = mwdata;
          end
          last_poll = (mreg == 5'h11 && !mwrite);
          if (log_n == cfg_err) merr <= 1'b1;
          else begin
            mdone <= 1'b1;
            if (mwrite) begin
              if (mreg == 5'h10) m_page = mwdata[15:8];
              else if (mreg >= 5'h18 && mreg <= 5'h1B) m_dreg[mreg - 5'h18] = mwdata;
              else if (mreg == 5'h11) begin
                m_cmd = mwdata;
                busy_left = cfg_busy;
                if (mwdata[1]) for (int i = 0; i < 4; i++)
                  m_dreg[i] = mem[{m_page[1:0], mwdata[10:8]}][i*16 +: 16];
                if (mwdata[0])
                  mem[{m_page[1:0], mwdata[10:8]}] = {m_dreg[3], m_dreg[2], m_dreg[1], m_dreg[0]};
              end
              mrdata <= 16'h0;
            end else if (mreg == 5'h11) begin
              if (busy_left > 0) begin
                mrdata <= m_cmd; busy_left = busy_left - 1;
              end else mrdata <= m_cmd & 16'hFFFC;
            end else if (mreg >= 5'h18 && mreg <= 5'h1B) mrdata <= m_dreg[mreg - 5'h18];
            else mrdata <= 16'h0;
          end
          log_n = log_n + 1;
        end
      end
    end
  end

  // reference state
  logic [7:0]  exp_cache = 8'hFF;
  logic [63:0] exp_mem [32];
  logic [15:0] exp_dreg [4];

  function automatic int nwords(input logic [2:0] w);
    case (w) 3'd0, 3'd1: return 1; 3'd2: return 2; 3'd3: return 3; default: return 4; endcase
  endfunction

  function automatic logic [63:0] wmask(input logic [2:0] w);
    case (w)
      3'd0: return 64'hFF; 3'd1: return 64'hFFFF; 3'd2: return 64'hFFFF_FFFF;
      3'd3: return 64'hFFFF_FFFF_FFFF; default: return {64{1'b1}};
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  logic [4:0]  e_reg [64];
  logic        e_wr [64];
  logic [15:0] e_wd [64];

  task automatic access(input string tag, input bit wr, input logic [7:0] pg,
                        input logic [7:0] off, input logic [2:0] w,
                        input logic [63:0] wd, input int busy, input int errpos);
    int n = 0, cmd_idx, polls, nw, cyc;
    bit timeout, exp_err, cmd_ok, seq_ok, ready_bad, got_done, got_err;
    logic [4:0] key;
    logic [63:0] got_rd;
    nw = nwords(w);
    key = {pg[1:0], off[2:0]};
    if (pg != exp_cache) begin e_reg[n] = 5'h10; e_wr[n] = 1; e_wd[n] = {pg, 7'b0, 1'b1}; n++; end
    if (wr) for (int i = 0; i < nw; i++) begin
      e_reg[n] = 5'h18 + 5'(i); e_wr[n] = 1; e_wd[n] = wd[i*16 +: 16]; n++;
    end
    e_reg[n] = 5'h11; e_wr[n] = 1; e_wd[n] = {off, 6'b0, ~wr, wr}; cmd_idx = n; n++;
    timeout = (busy >= LIMIT);
    polls = timeout ? LIMIT : busy + 1;
    for (int i = 0; i < polls; i++) begin e_reg[n] = 5'h11; e_wr[n] = 0; e_wd[n] = 0; n++; end
    if (!timeout && !wr) for (int i = 0; i < nw; i++) begin
      e_reg[n] = 5'h18 + 5'(i); e_wr[n] = 0; e_wd[n] = 0; n++;
    end
    exp_err = timeout;
    if (errpos >= 0 && errpos < n) begin n = errpos + 1; exp_err = 1; end
    cmd_ok = !(errpos >= 0 && errpos <= cmd_idx);

    @(negedge clk);
    cfg_busy = busy; cfg_err = errpos; log_n = 0;
    req_write = wr; req_page = pg; req_offset = off; req_width = w; req_wdata = wd;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 0; ready_bad = 0;
    while (!(rsp_done || rsp_error) && cyc < 3000) begin
      if (req_ready) ready_bad = 1;
      @(negedge clk); cyc++;
    end
    got_done = rsp_done; got_err = rsp_error; got_rd = rsp_rdata;

    if (pg != exp_cache && errpos != 0) exp_cache = pg;
    if (cmd_ok) begin
      if (wr) begin
        for (int i = 0; i < nw; i++) exp_dreg[i] = wd[i*16 +: 16];
        exp_mem[key] = {exp_dreg[3], exp_dreg[2], exp_dreg[1], exp_dreg[0]};
      end else for (int i = 0; i < 4; i++) exp_dreg[i] = exp_mem[key][i*16 +: 16];
    end

    seq_ok = (log_n == n);
    if (seq_ok) for (int i = 0; i < n; i++)
      if (log_reg[i] != e_reg[i] || log_wr[i] != e_wr[i] || (e_wr[i] && log_wd[i] != e_wd[i]))
        seq_ok = 0;
    check(seq_ok, tag, "transaction sequence (count)", 64'(log_n), 64'(n));
    check(!ready_bad && !(got_done && got_err), "R8", "ready low while busy", 64'(ready_bad), 0);
    check(got_err == exp_err && got_done == !exp_err, tag, "outcome error flag",
          64'(got_err), 64'(exp_err));
    if (!exp_err)
      check(got_rd == (wr ? 64'h0 : (exp_mem[key] & wmask(w))), "R6", "read data",
            got_rd, wr ? 64'h0 : (exp_mem[key] & wmask(w)));
  endtask

  bit finished = 0;
  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      failures++; checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) begin
      mem[i] = {32'(i) * 32'h9E37_79B9, 32'(i) ^ 32'hA5A5_5A5A};
      exp_mem[i] = mem[i];
    end
    for (int i = 0; i < 4; i++) begin m_dreg[i] = 16'h0; exp_dreg[i] = 16'h0; end
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(req_ready && !rsp_done && !rsp_error && !mvalid, "R1", "reset outputs",
          {60'h0, req_ready, rsp_done, rsp_error, mvalid}, 64'h8);
    rst_n = 1'b1;
    @(negedge clk);

    access("R1", 0, 8'h01, 8'h02, 3'd1, 0, 0, -1);
    access("R2", 1, 8'h01, 8'h03, 3'd4, 64'h1122_3344_5566_7788, 1, -1);
    access("R3", 0, 8'h01, 8'h03, 3'd4, 0, 0, -1);
    access("R6", 0, 8'h01, 8'h03, 3'd0, 0, 2, -1);
    access("R2", 1, 8'h02, 8'h01, 3'd2, 64'hDEAD_BEEF_CAFE_F00D, 0, -1);
    access("R6", 0, 8'h02, 8'h01, 3'd3, 0, 0, -1);
    access("R3", 1, 8'h02, 8'h04, 3'd0, 64'h0000_0000_0000_ABCD, 0, -1);
    access("R6", 0, 8'h02, 8'h04, 3'd7, 0, 0, -1);
    access("R4", 0, 8'h00, 8'h05, 3'd1, 0, 4, -1);
    access("R5", 0, 8'h00, 8'h05, 3'd1, 0, 5, -1);
    access("R5", 1, 8'h00, 8'h06, 3'd2, 64'h0123_4567, 7, -1);
    access("R7", 0, 8'h03, 8'h01, 3'd1, 0, 0, 0);
    access("R7", 0, 8'h03, 8'h01, 3'd1, 0, 0, -1);
    access("R7", 0, 8'h03, 8'h02, 3'd2, 0, 3, 2);
    access("R7", 0, 8'h03, 8'h02, 3'd4, 0, 0, 4);

    for (int k = 0; k < 80; k++) begin
      bit wr = 1'($urandom % 2);
      int ep = -1;
      if (!wr && ($urandom % 6 == 0)) ep = int'($urandom % 9);
      access(wr ? "R3" : "R6", wr, 8'($urandom % 4), 8'($urandom % 8), 3'($urandom % 5),
             {$urandom, $urandom}, int'($urandom % 7), ep);
    end

    check(gap_seen > 0 && gap_bad == 0, "R5", "poll gap violations", 64'(gap_bad), 0);
    check(phy_bad == 0, "R9", "wrong phy address", 64'(phy_bad), 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule